// File: doc/BRIEF.md
# Half-Table Constant-Coefficient Multiplier

This block forms the unsigned product of an N-bit operand and a coefficient that is fixed when the design is elaborated. It has no clock. A lookup table is used in place of a general multiplier, and this table keeps only half of the sixteen multiples that a 4-bit digit can select. The missing multiples are rebuilt by one add or one subtract of the coefficient, and the least significant bit of the digit chooses which value goes out.

A storage option picks which half is kept. The even option keeps 0, 2H and so on up to 14H. The odd option keeps H, 3H and so on up to 15H. An 8-bit operand uses two digit lanes that read one shared table, and the upper lane's result is shifted left by four before the two are summed. Wider operands are built recursively from two half-width multipliers that are joined the same way.

The block suits constant-coefficient filter taps, where a full table for every digit would cost twice the storage.

Top module: `hcm_mult`

## Requirements
- R1: Each 4-bit digit of the operand uses its three upper bits (bits 3..1), through a one-hot 3-to-8 decode, to pick one of 8 table entries. Each entry is W+4 bits wide.
- R2: With even storage (STORE_EVEN, encoded 0), entry k holds 2·k·H. A digit whose bit 0 is 0 outputs the entry unchanged. A digit whose bit 0 is 1 outputs the entry plus H.
- R3: With odd storage (STORE_ODD, encoded 1), entry k holds (2·k+1)·H. A digit whose bit 0 is 1 outputs the entry unchanged. A digit whose bit 0 is 0 outputs the entry minus H.
- R4: An operand of zero gives a product of zero in both storage options, and a coefficient of zero gives zero for every operand. No extra clearing logic is used for either case.
- R5: For N=8, the product equals X·H for all 256 operands. It is formed as (upper-digit result shifted left by 4) plus the lower-digit result.
- R6: For N=4, a single digit lane drives the product directly, and the product equals X·H.
- R7: For N=16 and N=32, the product equals X·H. It is formed as (upper half-width product shifted left by N/2) plus the lower half-width product.
- R8: The path from operand to product is purely combinational. The product reflects a new operand within the same cycle.
- R9: The product is W+N bits wide and never overflows, including the largest operand combined with the largest coefficient.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | N | Unsigned operand |
| product | output | W+N | Unsigned product x·COEF |

## Verification
The bench builds the block with N=8 and W=8 in both storage options, using coefficients of 13, 0 and 255. With these settings, every operand value can be compared against the product, which covers every table entry on both lanes and every add or subtract correction. A 4-bit pair (W=6, coefficient 45) checks the single-lane variant. A 16-bit even instance and a 32-bit odd instance with a 12-bit all-ones coefficient check the recursive joins, using edge patterns that exercise carries across the half boundaries and the widest product.

// File: rtl/hcm_pkg.sv
package hcm_pkg;

   typedef enum logic {
      STORE_EVEN = 1'b0,
      STORE_ODD  = 1'b1
   } store_mode_e;

   // Width of one operand digit served by a table lane
   localparam int unsigned DIGIT_W = 4;

   // Multiple of the coefficient held in table slot k
   function automatic int unsigned slot_multiple(store_mode_e mode, int unsigned k);
      return (mode == STORE_ODD) ? (2 * k + 1) : (2 * k);
   endfunction

endpackage

// File: rtl/hcm_coef_rom.sv
module hcm_coef_rom
   import hcm_pkg::*;
#(
   parameter int unsigned          W     = 8,
   parameter logic [W-1:0]         COEF  = '0,
   parameter store_mode_e          MODE  = STORE_EVEN,
   localparam int unsigned         EW    = W + DIGIT_W,
   localparam int unsigned         DEPTH = 1 << (DIGIT_W - 1)
) (
   output logic [DEPTH*EW-1:0]     entries
);

   localparam logic [EW-1:0] COEF_X = EW'(COEF);

   for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      localparam int unsigned MULT = slot_multiple(MODE, k);
      assign entries[k*EW +: EW] = COEF_X * EW'(MULT);
   end

endmodule

// File: rtl/hcm_digit_lane.sv
module hcm_digit_lane
   import hcm_pkg::*;
#(
   parameter int unsigned          W     = 8,
   parameter logic [W-1:0]         COEF  = '0,
   parameter store_mode_e          MODE  = STORE_EVEN,
   localparam int unsigned         EW    = W + DIGIT_W,
   localparam int unsigned         DEPTH = 1 << (DIGIT_W - 1),
   localparam int unsigned         SEL_W = DIGIT_W - 1
) (
   input  logic [DIGIT_W-1:0]      digit,
   input  logic [DEPTH*EW-1:0]     entries,
   output logic [EW-1:0]           res
);

   localparam logic [EW-1:0] COEF_X = EW'(COEF);
   localparam logic [EW-1:0] MAX_V  = COEF_X * EW'((1 << DIGIT_W) - 1);

   logic [SEL_W-1:0] sel;
   logic [DEPTH-1:0] onehot;
   logic [EW-1:0]    fetched;
   logic [EW-1:0]    alt;

   always_comb begin
      sel    = digit[DIGIT_W-1:1];
      onehot = '0;
      onehot[sel] = 1'b1;
      fetched = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (onehot[k]) fetched = fetched | entries[k*EW +: EW];
      end
      if (MODE == STORE_EVEN) begin
         alt = fetched + COEF_X;
         res = digit[0] ? alt : fetched;
      end else begin
         alt = fetched - COEF_X;
         res = digit[0] ? fetched : alt;
      end

      if (!$isunknown({digit, entries})) begin
         // R2 R3
         lane_product_chk: assert (res == EW'(digit) * COEF_X)
            else $error("lane result %0d wrong for digit %0d", res, digit);
         // R4
         lane_zero_chk: assert ((digit != '0) || (res == '0))
            else $error("zero digit gave %0d", res);
         // R9
         lane_bound_chk: assert (res <= MAX_V)
            else $error("lane result %0d above %0d", res, MAX_V);
      end
   end

endmodule

// File: rtl/hcm_byte_core.sv
module hcm_byte_core
   import hcm_pkg::*;
#(
   parameter int unsigned          W    = 8,
   parameter logic [W-1:0]         COEF = '0,
   parameter store_mode_e          MODE = STORE_EVEN,
   localparam int unsigned         BW   = 2 * DIGIT_W,
   localparam int unsigned         EW   = W + DIGIT_W,
   localparam int unsigned         PW   = W + BW,
   localparam int unsigned         DEPTH = 1 << (DIGIT_W - 1)
) (
   input  logic [BW-1:0]           x,
   output logic [PW-1:0]           product
);

   logic [DEPTH*EW-1:0] entries;
   logic [EW-1:0]       lane_res [2];

   // one table, read by both lanes
   hcm_coef_rom #(.W(W), .COEF(COEF), .MODE(MODE)) u_rom (
      .entries (entries)
   );

   for (genvar g = 0; g < 2; g++) begin : g_lane
      hcm_digit_lane #(.W(W), .COEF(COEF), .MODE(MODE)) u_lane (
         .digit   (x[g*DIGIT_W +: DIGIT_W]),
         .entries (entries),
         .res     (lane_res[g])
      );
   end

   always_comb begin
      product = (PW'(lane_res[1]) << DIGIT_W) + PW'(lane_res[0]);
      if (!$isunknown({lane_res[1], lane_res[0]})) begin
         // R5
         join_low_bits_chk: assert (product[DIGIT_W-1:0] == lane_res[0][DIGIT_W-1:0])
            else $error("low digit bits disturbed by join");
         // R9
         join_no_overflow_chk: assert (product >= (PW'(lane_res[1]) << DIGIT_W))
            else $error("byte join overflowed");
      end
   end

endmodule

// File: rtl/hcm_mult.sv
module hcm_mult
   import hcm_pkg::*;
#(
   parameter int unsigned          N    = 8,
   parameter int unsigned          W    = 8,
   parameter logic [W-1:0]         COEF = W'(13),
   parameter store_mode_e          MODE = STORE_EVEN,
   localparam int unsigned         PW   = W + N,
   localparam int unsigned         HALF = N / 2
) (
   input  logic [N-1:0]            x,
   output logic [PW-1:0]           product
);

   if (N < DIGIT_W || (N & (N - 1)) != 0) begin : g_bad_n
      $error("hcm_mult: N=%0d must be a power of two of at least 4", N);
   end
   if (W < 1) begin : g_bad_w
      $error("hcm_mult: W must be at least 1");
   end

   if (N == DIGIT_W) begin : g_single
      localparam int unsigned EW    = W + DIGIT_W;
      localparam int unsigned DEPTH = 1 << (DIGIT_W - 1);
      logic [DEPTH*EW-1:0] entries;

      hcm_coef_rom #(.W(W), .COEF(COEF), .MODE(MODE)) u_rom (
         .entries (entries)
      );
      hcm_digit_lane #(.W(W), .COEF(COEF), .MODE(MODE)) u_lane (
         .digit   (x),
         .entries (entries),
         .res     (product)
      );
   end else if (N == 2 * DIGIT_W) begin : g_byte
      hcm_byte_core #(.W(W), .COEF(COEF), .MODE(MODE)) u_core (
         .x       (x),
         .product (product)
      );
   end else begin : g_split
      logic [W+HALF-1:0] lo_p;
      logic [W+HALF-1:0] hi_p;

      hcm_mult #(.N(HALF), .W(W), .COEF(COEF), .MODE(MODE)) u_lo (
         .x       (x[HALF-1:0]),
         .product (lo_p)
      );
      hcm_mult #(.N(HALF), .W(W), .COEF(COEF), .MODE(MODE)) u_hi (
         .x       (x[N-1:HALF]),
         .product (hi_p)
      );

      always_comb begin
         product = (PW'(hi_p) << HALF) + PW'(lo_p);
         if (!$isunknown({hi_p, lo_p})) begin
            // R7
            split_low_bits_chk: assert (product[HALF-1:0] == lo_p[HALF-1:0])
               else $error("low half bits disturbed by join");
            // R9
            split_no_overflow_chk: assert (product >= (PW'(hi_p) << HALF))
               else $error("split join overflowed");
         end
      end
   end

endmodule

// File: tb/hcm_mult_tb_top.sv
module hcm_mult_tb_top;
   import hcm_pkg::*;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   int checks   = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [7:0]  x8  = '0;
   logic [3:0]  x4  = '0;
   logic [15:0] x16 = '0;
   logic [31:0] x32 = '0;

   logic [15:0] p_e13, p_o13, p_e0, p_o0, p_e255, p_o255;
   logic [9:0]  p4_e, p4_o;
   logic [23:0] p16;
   logic [43:0] p32;

   hcm_mult #(.N(8), .W(8), .COEF(8'd13),  .MODE(STORE_EVEN)) dut_i  (.x(x8), .product(p_e13));
   hcm_mult #(.N(8), .W(8), .COEF(8'd13),  .MODE(STORE_ODD))  u_o13  (.x(x8), .product(p_o13));
   hcm_mult #(.N(8), .W(8), .COEF(8'd0),   .MODE(STORE_EVEN)) u_e0   (.x(x8), .product(p_e0));
   hcm_mult #(.N(8), .W(8), .COEF(8'd0),   .MODE(STORE_ODD))  u_o0   (.x(x8), .product(p_o0));
   hcm_mult #(.N(8), .W(8), .COEF(8'd255), .MODE(STORE_EVEN)) u_e255 (.x(x8), .product(p_e255));
   hcm_mult #(.N(8), .W(8), .COEF(8'd255), .MODE(STORE_ODD))  u_o255 (.x(x8), .product(p_o255));
   hcm_mult #(.N(4), .W(6), .COEF(6'd45),  .MODE(STORE_EVEN)) u_n4e  (.x(x4), .product(p4_e));
   hcm_mult #(.N(4), .W(6), .COEF(6'd45),  .MODE(STORE_ODD))  u_n4o  (.x(x4), .product(p4_o));
   hcm_mult #(.N(16), .W(8), .COEF(8'd200), .MODE(STORE_EVEN)) u_w16 (.x(x16), .product(p16));
   hcm_mult #(.N(32), .W(12), .COEF(12'hFFF), .MODE(STORE_ODD)) u_w32 (.x(x32), .product(p32));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // operands change at the falling edge, results are read 1 ns later
   task automatic settle();
      #1;
   endtask

   task automatic t_zero();
      @(negedge clk);
      x8 = '0; x4 = '0; x16 = '0; x32 = '0;
      settle();
      chk("R4 even zero", 64'(p_e13), 0);
      chk("R4 odd zero",  64'(p_o13), 0);
      chk("R4 odd zero H=255", 64'(p_o255), 0);
      chk("R4 N4 odd zero", 64'(p4_o), 0);
      chk("R4 N16 zero", 64'(p16), 0);
      chk("R4 N32 odd zero", 64'(p32), 0);
   endtask

   task automatic t_sweep8();
      for (int v = 0; v < 256; v++) begin
         @(negedge clk);
         x8 = 8'(v);
         settle();
         chk("R1 R2 R5 even H=13",  64'(p_e13),  64'(v * 13));
         chk("R1 R3 R5 odd H=13",   64'(p_o13),  64'(v * 13));
         chk("R4 even H=0",         64'(p_e0),   0);
         chk("R4 odd H=0",          64'(p_o0),   0);
         chk("R9 even H=255",       64'(p_e255), 64'(v * 255));
         chk("R9 odd H=255",        64'(p_o255), 64'(v * 255));
      end
   endtask

   task automatic t_nibble4();
      for (int v = 0; v < 16; v++) begin
         @(negedge clk);
         x4 = 4'(v);
         settle();
         chk("R6 R2 N4 even", 64'(p4_e), 64'(v * 45));
         chk("R6 R3 N4 odd",  64'(p4_o), 64'(v * 45));
      end
   endtask

   task automatic t_wide16();
      logic [15:0] pats [6] = '{16'h0001, 16'hFFFF, 16'h8000, 16'h00F0, 16'h0FF1, 16'hA5C3};
      foreach (pats[i]) begin
         @(negedge clk);
         x16 = pats[i];
         settle();
         chk("R7 N16", 64'(p16), 64'(pats[i]) * 64'd200);
      end
   endtask

   task automatic t_wide32();
      logic [31:0] pats [6] = '{32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000,
                                 32'h0000_FFFF, 32'hFFFF_0000, 32'h1234_5678};
      foreach (pats[i]) begin
         @(negedge clk);
         x32 = pats[i];
         settle();
         chk("R7 R9 N32", 64'(p32), 64'(pats[i]) * 64'd4095);
      end
   endtask

   // R8: a new operand shows in the same cycle, with no clock edge between
   task automatic t_comb();
      @(negedge clk);
      x8 = 8'd77;
      #0.5;
      chk("R8 same-cycle even", 64'(p_e13), 64'd1001);
      x8 = 8'd150;
      #0.5;
      chk("R8 same-cycle odd", 64'(p_o13), 64'd1950);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_zero();
      t_sweep8();
      t_nibble4();
      t_wide16();
      t_wide32();
      t_comb();
      finish_run();
   end

   initial begin
      int cycles = 0;
      while (cycles < 20000) begin
         @(posedge clk);
         if (!rst) cycles++;
      end
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
      finish_run();
   end

endmodule